// File: doc/BRIEF.md
# Microcode Loader and Sequencer Control

This block sits between a host register bus and a small microsequencer. It keeps the sequencer's execution mode in a three-bit control register and owns the instruction pointer. It also holds the local instruction memory, which stores 40-bit microcode words. The host reaches that memory through a loading port made of two 32-bit registers. While the block is in load mode, each commit or read-back of a full word moves the pointer on by one. The host can therefore stream a whole program without ever writing an address.

On the sequencer side the block drives a run flag, the current instruction pointer and the instruction word at that pointer. Instruction decode and execution are outside this block. While the run flag is high, the pointer steps by one on every clock and wraps at the end of memory.

The host bus has no wait states. Read data is a combinational function of the address, and a write takes effect on the clock edge where the write strobe is high. Addresses are byte addresses of 32-bit registers. The control register is at 0x0, the low loading word at 0x4, the high loading word at 0x8 and the error status at 0xC. An address whose two low bits are not zero selects nothing.

Top module: `useq_ctrl`

## Requirements
- R1: The control register at 0x0 holds halt in bit 0 and load in bit 1, and bit 2 is the pointer-reset command. A read of 0x0 returns halt and load, returns 0 in bit 2 and returns 0 in bits 31..3.
- R2: After reset, halt is 1, load is 0, seq_run is 0, seq_ip is 0, and the error flag (bit 0 of 0xC, all other bits 0) is 0.
- R3: A legal write to 0x0 with bit 2 = 1 sets seq_ip to 0 at that clock edge, and this takes priority over any pointer step. The command does not persist, so later cycles resume normal stepping.
- R4: With halt = 1 and load = 0, seq_run is 0 and seq_ip holds its value.
- R5: With load = 1, seq_run is 0 and the loading port works as follows:
  - A write to 0x4 stages bits 31..0 and leaves seq_ip unchanged.
  - A write to 0x8 stores {wdata[7:0], staged bits} at seq_ip and advances seq_ip by one.
  - A read of 0x4 returns bits 31..0 of the word at seq_ip and does not advance the pointer.
  - A read of 0x8 returns {24'b0, bits 39..32} of the word at seq_ip and advances seq_ip by one.
  - The advance wraps from DEPTH-1 to 0.
- R6: With halt = 0 and load = 0, seq_run is 1 and seq_ip steps by one every cycle, wrapping from DEPTH-1 to 0.
  - A write of 0x4 to 0x0 (start) restarts the program from 0.
  - A write of 0x0 to 0x0 continues from the current pointer.
- R7: seq_instr always equals the stored 40-bit word at seq_ip.
- R8: A write to 0x0 with bits 2 and 1 both 1 is ignored, so halt, load and seq_ip are unaffected by it. It sets the error flag, which stays 1 until reset.
- R9: Outside load mode, writes to 0x4 and 0x8 change neither memory nor the staged word, and accesses to 0x8 do not move seq_ip. Reads of 0x4 and 0x8 still return the word at seq_ip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_addr | input | ADDR_W | Byte address of the host register |
| bus_wdata | input | 32 | Host write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| seq_run | output | 1 | High while the sequencer executes |
| seq_ip | output | IP_W | Instruction pointer |
| seq_instr | output | 40 | Instruction word at seq_ip |

## Verification
The assertions assume that the host never raises the write and read strobes in the same cycle. They also assume that the strobes are only ever 0 or 1 and that the address is stable while a strobe is high. The bench follows these rules by running every access through one task that drives a single strobe, changes inputs only on the falling edge and holds each access for exactly one cycle. The pointer properties count only accesses at word-aligned addresses, which matches the block's own decode. The bench issues only aligned addresses.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int BUS_W    = 32;
  localparam int INSTR_W  = 40;
  localparam int HI_W     = INSTR_W - BUS_W;
  localparam int CTRL_IDX = 0;
  localparam int LO_IDX   = 1;
  localparam int HI_IDX   = 2;
  localparam int STAT_IDX = 3;
  localparam int BIT_HALT = 0;
  localparam int BIT_LOAD = 1;
  localparam int BIT_PRST = 2;

  typedef struct packed {
    logic load;
    logic halt;
  } mode_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/useq_regs.sv
module useq_regs
  import useq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [INSTR_W-1:0] cur_word,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               run,
  output logic               load_mode,
  output logic               err_flag,
  output logic               ip_clr,
  output logic               port_step,
  output logic               mem_we,
  output logic [INSTR_W-1:0] mem_wdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             sel_ctrl, sel_lo, sel_hi, sel_stat;
  logic             ctrl_wr, bad_combo;

  mode_t            mode_q, mode_d;
  logic             mode_en;
  logic             err_q, err_d, err_en;
  logic [BUS_W-1:0] stage_q, stage_d;
  logic             stage_en;

  // address decode
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign idx      = bus_addr[ADDR_W-1:2];
  assign sel_ctrl = aligned && (idx == IDX_W'(CTRL_IDX));
  assign sel_lo   = aligned && (idx == IDX_W'(LO_IDX));
  assign sel_hi   = aligned && (idx == IDX_W'(HI_IDX));
  assign sel_stat = aligned && (idx == IDX_W'(STAT_IDX));

  assign ctrl_wr   = bus_wr && sel_ctrl;
  assign bad_combo = bus_wdata[BIT_PRST] && bus_wdata[BIT_LOAD];

  // next-state
  always_comb begin
    mode_d   = mode_q;
    mode_en  = 1'b0;
    err_d    = err_q;
    err_en   = 1'b0;
    stage_d  = stage_q;
    stage_en = 1'b0;
    if (ctrl_wr) begin
      if (bad_combo) begin
        err_d  = 1'b1;
        err_en = 1'b1;
      end else begin
        mode_d.halt = bus_wdata[BIT_HALT];
        mode_d.load = bus_wdata[BIT_LOAD];
        mode_en     = 1'b1;
      end
    end
    if (mode_q.load && bus_wr && sel_lo) begin
      stage_d  = bus_wdata;
      stage_en = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{load: 1'b0, halt: 1'b1};
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  // sequencer-side controls
  assign run       = !mode_q.halt && !mode_q.load;
  assign load_mode = mode_q.load;
  assign err_flag  = err_q;
  assign ip_clr    = ctrl_wr && bus_wdata[BIT_PRST] && !bus_wdata[BIT_LOAD];
  assign port_step = mode_q.load && sel_hi && (bus_wr || bus_rd);
  assign mem_we    = mode_q.load && sel_hi && bus_wr;
  assign mem_wdata = {bus_wdata[HI_W-1:0], stage_q};

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[BIT_HALT] = mode_q.halt;
      bus_rdata[BIT_LOAD] = mode_q.load;
    end else if (sel_lo) begin
      bus_rdata = cur_word[BUS_W-1:0];
    end else if (sel_hi) begin
      bus_rdata[HI_W-1:0] = cur_word[INSTR_W-1:BUS_W];
    end else if (sel_stat) begin
      bus_rdata[0] = err_q;
    end
  end
endmodule

// File: rtl/useq_iptr.sv
module useq_iptr #(
  parameter int DEPTH = 16,
  localparam int IP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            port_step,
  output logic [IP_W-1:0] ip
);
  localparam logic [IP_W-1:0] LAST = IP_W'(DEPTH - 1);

  logic [IP_W-1:0] ip_q, ip_d;
  logic            ip_en;

  always_comb begin
    ip_en = clr || run || port_step;
    if (clr)              ip_d = '0;
    else if (ip_q == LAST) ip_d = '0;
    else                  ip_d = ip_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= '0;
    else if (ip_en) ip_q <= ip_d;
  end

  assign ip = ip_q;
endmodule

// File: rtl/useq_imem.sv
module useq_imem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 40,
  localparam int IP_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IP_W-1:0]   addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  localparam int IP_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               seq_run,
  output logic [IP_W-1:0]    seq_ip,
  output logic [INSTR_W-1:0] seq_instr
);
  logic               rst_sync_n;
  logic               run, load_mode, err_flag;
  logic               ip_clr, port_step, mem_we;
  logic [INSTR_W-1:0] mem_wdata, cur_word;
  logic [IP_W-1:0]    ip;

  useq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  useq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cur_word  (cur_word),
    .bus_rdata (bus_rdata),
    .run       (run),
    .load_mode (load_mode),
    .err_flag  (err_flag),
    .ip_clr    (ip_clr),
    .port_step (port_step),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  useq_iptr #(.DEPTH(DEPTH)) u_iptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (ip_clr),
    .run       (run),
    .port_step (port_step),
    .ip        (ip)
  );

  useq_imem #(.DEPTH(DEPTH), .WORD_W(INSTR_W)) u_imem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ip),
    .wdata (mem_wdata),
    .rdata (cur_word)
  );

  assign seq_run   = run;
  assign seq_ip    = ip;
  assign seq_instr = cur_word;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  localparam int IP_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              seq_run,
  input logic [IP_W-1:0]   seq_ip,
  input logic              load_q,
  input logic              err_q
);
  localparam logic [IP_W-1:0] LAST = IP_W'(DEPTH - 1);

  logic ctrl_acc, hi_acc, ctrl_wr, ctrl_seen;

  assign ctrl_acc = (bus_addr == ADDR_W'(0));
  assign hi_acc   = (bus_addr == ADDR_W'(8));
  assign ctrl_wr  = bus_wr && ctrl_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_seen <= 1'b0;
    else if (ctrl_wr) ctrl_seen <= 1'b1;
  end

  // R1: reserved and write-only control bits read back as zero
  p_ctrl_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ctrl_acc) |-> (bus_rdata[31:2] == 30'd0));

  // R2: stopped until the first control write
  p_stopped_from_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_seen |-> !seq_run);

  // R3: pointer-reset command zeroes the pointer
  p_prst_clears_ip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[2] && !bus_wdata[1]) |=> (seq_ip == '0));

  // R4 and R9: stalled pointer holds unless a load-mode port access moves it
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_run && !ctrl_wr && !(load_q && hi_acc && (bus_wr || bus_rd)))
      |=> $stable(seq_ip));

  // R5: high-half access in load mode steps the pointer with wrap
  p_load_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && hi_acc && (bus_wr || bus_rd) && !ctrl_wr)
      |=> (seq_ip == (($past(seq_ip) == LAST) ? '0 : $past(seq_ip) + 1'b1)));

  // R6: running pointer steps every cycle with wrap
  p_run_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_run && !ctrl_wr)
      |=> (seq_ip == (($past(seq_ip) == LAST) ? '0 : $past(seq_ip) + 1'b1)));

  // R8: illegal combination leaves the mode alone and raises the flag
  p_illegal_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[2] && bus_wdata[1])
      |=> (err_q && $stable(load_q) && $stable(seq_run)));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

bind useq_ctrl useq_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .seq_run   (seq_run),
  .seq_ip    (seq_ip),
  .load_q    (load_mode),
  .err_q     (err_flag)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 4;
  localparam int IP_W   = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_wr, bus_rd;
  logic [31:0]       bus_rdata;
  logic              seq_run;
  logic [IP_W-1:0]   seq_ip;
  logic [39:0]       seq_instr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [39:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  useq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .seq_run(seq_run), .seq_ip(seq_ip), .seq_instr(seq_instr)
  );

  function automatic logic [39:0] pattern(int k);
    return {8'(8'hA0 + k), 32'h1234_0000 + 32'(k) * 32'h0000_0101};
  endfunction

  task automatic check(string req, string what, logic [39:0] got, logic [39:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R2", "run after reset", 40'(seq_run), 40'd0);
    check("R2", "ip after reset", 40'(seq_ip), 40'd0);
    bus_read(4'h0, d);
    check("R2", "ctrl after reset", 40'(d), 40'h1);
    bus_read(4'hC, d);
    check("R2", "error flag after reset", 40'(d), 40'h0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    bus_write(4'h0, 32'hFFFF_FFFD);
    bus_read(4'h0, d);
    check("R1", "reserved and reset bits read zero", 40'(d), 40'h1);
    check("R3", "pointer reset gives ip 0", 40'(seq_ip), 40'd0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    bus_write(4'h0, 32'h3);
    bus_read(4'h0, d);
    check("R5", "load mode readback", 40'(d), 40'h3);
    check("R5", "stopped in load mode", 40'(seq_run), 40'd0);
    for (int k = 0; k < 4; k++) begin
      exp_mem[k] = pattern(k);
      bus_write(4'h4, exp_mem[k][31:0]);
      check("R5", "low write keeps ip", 40'(seq_ip), 40'(k));
      bus_write(4'h8, {24'd0, exp_mem[k][39:32]});
      check("R5", "high write advances ip", 40'(seq_ip), 40'(k + 1));
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bus_write(4'h0, 32'h5);
    bus_write(4'h0, 32'h3);
    for (int k = 0; k < 4; k++) begin
      check("R7", "instr output", seq_instr, exp_mem[k]);
      bus_read(4'h4, d);
      check("R5", "low read data", 40'(d), 40'(exp_mem[k][31:0]));
      check("R5", "low read keeps ip", 40'(seq_ip), 40'(k));
      bus_read(4'h8, d);
      check("R5", "high read data", 40'(d), 40'(exp_mem[k][39:32]));
      check("R5", "high read advances ip", 40'(seq_ip), 40'(k + 1));
    end
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    bus_write(4'h0, 32'h5);
    bus_write(4'h4, 32'hDEAD_BEEF);
    bus_write(4'h8, 32'h0000_00FF);
    check("R9", "writes outside load keep ip", 40'(seq_ip), 40'd0);
    check("R9", "write outside load leaves memory", seq_instr, exp_mem[0]);
    bus_read(4'h8, d);
    check("R9", "high read outside load data", 40'(d), 40'(exp_mem[0][39:32]));
    check("R9", "high read outside load keeps ip", 40'(seq_ip), 40'd0);
    bus_write(4'h0, 32'h3);
    bus_write(4'h8, 32'h0000_0055);
    exp_mem[0] = {8'h55, exp_mem[3][31:0]};
    bus_write(4'h0, 32'h5);
    bus_write(4'h0, 32'h3);
    bus_read(4'h4, d);
    check("R9", "staged word untouched outside load", 40'(d), 40'(exp_mem[0][31:0]));
  endtask

  task automatic t_run();
    bus_write(4'h0, 32'h4);
    check("R6", "start gives ip 0", 40'(seq_ip), 40'd0);
    check("R6", "start sets run", 40'(seq_run), 40'd1);
    check("R7", "fetch at start", seq_instr, exp_mem[0]);
    repeat (5) @(negedge clk);
    check("R6", "ip steps each cycle", 40'(seq_ip), 40'd5);
    bus_write(4'h0, 32'h1);
    check("R4", "halt stops run", 40'(seq_run), 40'd0);
    check("R4", "ip after halt edge", 40'(seq_ip), 40'd6);
    repeat (3) @(negedge clk);
    check("R4", "ip holds while halted", 40'(seq_ip), 40'd6);
    bus_write(4'h0, 32'h0);
    check("R6", "continue keeps ip", 40'(seq_ip), 40'd6);
    repeat (DEPTH - 6) @(negedge clk);
    check("R6", "ip wraps to 0", 40'(seq_ip), 40'd0);
    check("R7", "fetch after wrap", seq_instr, exp_mem[0]);
    @(negedge clk);
    check("R6", "ip after wrap", 40'(seq_ip), 40'd1);
    bus_write(4'h0, 32'h4);
    check("R3", "pointer reset while running", 40'(seq_ip), 40'd0);
    bus_write(4'h0, 32'h1);
    check("R3", "reset does not persist", 40'(seq_ip), 40'd1);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    logic [IP_W-1:0] ip0;
    ip0 = seq_ip;
    bus_write(4'h0, 32'h6);
    bus_read(4'h0, d);
    check("R8", "illegal write ignored", 40'(d), 40'h1);
    check("R8", "ip unaffected", 40'(seq_ip), 40'(ip0));
    check("R8", "still stopped", 40'(seq_run), 40'd0);
    bus_read(4'hC, d);
    check("R8", "error flag set", 40'(d), 40'h1);
    bus_write(4'h0, 32'h5);
    bus_read(4'hC, d);
    check("R8", "error flag sticky", 40'(d), 40'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_load();
    t_readback();
    t_ignore();
    t_run();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule